// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM

This block forms the address half of a synchronous burst SRAM controller. A cycle opens when one of two start strobes is sampled. The processor-side strobe `cpu_stb` counts only while the master enable is active. The controller-side strobe `ctl_stb` is always taken. When a cycle opens, the block captures the start address. It then sweeps the two least significant address bits through a four-beat group, one beat for each clock on which `adv` is high. A fixed linear order or an exclusive-or (interleaved) order is chosen when the cycle opens. The upper address bits do not move during a burst.

A taken strobe starts a burst only when the master enable and every secondary enable are active. Otherwise the taken strobe closes the current cycle as a deselect. A processor-side start is always a read. A controller-side start is a write when `wr_req` is high. The array, the data path and the pad timing sit outside this block.

The control is a three-state machine:
- `ST_IDLE`: no cycle in progress.
- `ST_RD`: read burst in progress.
- `ST_WR`: write burst in progress.

The transitions are:
- From any state to `ST_RD`: a qualified processor start, or a qualified controller start with `wr_req` low.
- From any state to `ST_WR`: a qualified controller start with `wr_req` high.
- From any state to `ST_IDLE`: a taken strobe with any enable inactive.
- Otherwise the state is kept.

Every input is sampled on a rising clock edge, and the outputs change after that same edge.

Top module: `burst_seq`

## Requirements
- R1: A strobe that is taken while all enables are active loads `addr_in`. After that edge, `mem_addr` equals `addr_in` and `cyc_valid` is 1.
- R2: While no strobe is taken, `mem_addr[ADDR_W-1:2]` keeps the loaded value.
- R3: With `interleave`=0 at the start, beat k (k = number of `adv` edges since the start) has low bits equal to (start low bits + k) mod 4.
- R4: With `interleave`=1 at the start, beat k has low bits equal to start low bits XOR (k mod 4).
- R5: `cpu_stb` has no effect while `master_en` is 0: `mem_addr`, `cyc_valid` and `cyc_write` keep their values.
- R6: `ctl_stb` is taken while `master_en` is 0, and it produces a deselect: `cyc_valid` becomes 0.
- R7: A qualified `ctl_stb` in the middle of a burst loads the new address and restarts the beat count at 0.
- R8: With `adv`=0 and no strobe taken, `mem_addr` holds.
- R9: A controller start with `wr_req`=1 gives `cyc_write`=1. A processor start gives `cyc_write`=0 whatever the value of `wr_req`.
- R10: When both strobes are sampled with `master_en`=1, the processor strobe wins and the cycle is a read.
- R11: A taken strobe with any bit of `sec_en` at 0 gives a deselect: `cyc_valid` is 0.
- R12: After the fourth beat, further `adv` pulses wrap to the start address of the same group.
- R13: During and after reset, `cyc_valid`=0, `cyc_write`=0 and `mem_addr`=0.
- R14: In `ST_IDLE`, `adv` has no effect: `mem_addr` and `cyc_valid` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | Start address captured on a qualified strobe |
| cpu_stb | input | 1 | Processor-side start strobe, gated by `master_en` |
| ctl_stb | input | 1 | Controller-side start strobe, never gated |
| master_en | input | 1 | Master enable, active high |
| sec_en | input | NUM_SEC | Secondary enables, all active high |
| wr_req | input | 1 | Write request, used on controller starts only |
| adv | input | 1 | 1 = advance one beat, 0 = hold (wait state) |
| interleave | input | 1 | 1 = XOR order, 0 = linear order, captured at the start |
| mem_addr | output | ADDR_W | Current array address |
| cyc_valid | output | 1 | A burst cycle is active |
| cyc_write | output | 1 | The active cycle is a write |

## Verification
A wrong beat count or a wrong captured start value shows on `mem_addr[1:0]` one edge after the `adv` pulse that steps it. The near-exhaustive sweep over every start address in both orders, run past the wrap point, exposes that error on the first wrong beat. A wrong state-machine transition shows on `cyc_valid` or `cyc_write` one edge after the strobe that caused it. Each strobe-qualification corner is therefore checked on the cycle right after it.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bsq_state_e;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_START_RD = 2'd1,
        EV_START_WR = 2'd2,
        EV_DESEL    = 2'd3
    } bsq_event_e;
endpackage

// File: rtl/bsq_strobe_qual.sv
module bsq_strobe_qual
    import bsq_pkg::*;
#(
    parameter int NUM_SEC = 2
) (
    input  logic               cpu_stb,
    input  logic               ctl_stb,
    input  logic               master_en,
    input  logic [NUM_SEC-1:0] sec_en,
    input  logic               wr_req,
    output bsq_event_e         ev
);
    logic cpu_go;
    logic taken;
    logic all_en;

    always_comb begin
        cpu_go = cpu_stb & master_en;
        taken  = cpu_go | ctl_stb;
        all_en = master_en & (&sec_en);
        if (!taken)
            ev = EV_NONE;
        else if (!all_en)
            ev = EV_DESEL;
        else if (cpu_go)
            ev = EV_START_RD;      // processor start wins and is always a read
        else if (wr_req)
            ev = EV_START_WR;
        else
            ev = EV_START_RD;
    end
endmodule

// File: rtl/bsq_beat_gen.sv
module bsq_beat_gen
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] lo0_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              ilv_q;
    logic [BEAT_W-1:0] lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo0_q <= '0;
            cnt_q <= '0;
            ilv_q <= 1'b0;
        end else if (load) begin
            hi_q  <= addr_in[ADDR_W-1:BEAT_W];
            lo0_q <= addr_in[BEAT_W-1:0];
            cnt_q <= '0;
            ilv_q <= interleave;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;     // natural wrap closes the group
        end
    end

    always_comb begin
        if (ilv_q)
            lo = lo0_q ^ cnt_q;
        else
            lo = lo0_q + cnt_q;
        addr_out = {hi_q, lo};
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int NUM_SEC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               cpu_stb,
    input  logic               ctl_stb,
    input  logic               master_en,
    input  logic [NUM_SEC-1:0] sec_en,
    input  logic               wr_req,
    input  logic               adv,
    input  logic               interleave,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               cyc_valid,
    output logic               cyc_write
);
    bsq_state_e state_q;
    bsq_state_e state_d;
    bsq_event_e ev;
    logic       load;
    logic       step;

    bsq_strobe_qual #(.NUM_SEC(NUM_SEC)) u_qual (
        .cpu_stb   (cpu_stb),
        .ctl_stb   (ctl_stb),
        .master_en (master_en),
        .sec_en    (sec_en),
        .wr_req    (wr_req),
        .ev        (ev)
    );

    always_comb begin
        load = (ev == EV_START_RD) || (ev == EV_START_WR);
        step = (ev == EV_NONE) && adv && (state_q != ST_IDLE);
        unique case (ev)
            EV_START_RD: state_d = ST_RD;
            EV_START_WR: state_d = ST_WR;
            EV_DESEL:    state_d = ST_IDLE;
            default:     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    bsq_beat_gen #(.ADDR_W(ADDR_W)) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .addr_in    (addr_in),
        .interleave (interleave),
        .addr_out   (mem_addr)
    );

    always_comb begin
        unique case (state_q)
            ST_RD:   begin cyc_valid = 1'b1; cyc_write = 1'b0; end
            ST_WR:   begin cyc_valid = 1'b1; cyc_write = 1'b1; end
            default: begin cyc_valid = 1'b0; cyc_write = 1'b0; end
        endcase
    end
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W  = 21,
    parameter int NUM_SEC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr_in,
    input logic               cpu_stb,
    input logic               ctl_stb,
    input logic               master_en,
    input logic [NUM_SEC-1:0] sec_en,
    input logic               wr_req,
    input logic               adv,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               cyc_valid,
    input logic               cyc_write
);
    logic taken;
    logic all_en;

    assign taken  = (cpu_stb & master_en) | ctl_stb;
    assign all_en = master_en & (&sec_en);

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && all_en) |=> (cyc_valid && mem_addr == $past(addr_in)));

    a_r2_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> $stable(mem_addr[ADDR_W-1:2]));

    a_r5_cpu_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb && !master_en && !ctl_stb && !adv)
            |=> ($stable(mem_addr) && $stable(cyc_valid) && $stable(cyc_write)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken && !adv) |=> $stable(mem_addr));

    a_r9_cpu_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb && master_en && (&sec_en)) |=> (cyc_valid && !cyc_write));

    a_r9_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stb && !cpu_stb && all_en && wr_req) |=> (cyc_valid && cyc_write));

    a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !all_en) |=> !cyc_valid);

    a_r14_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_valid && !taken) |=> (!cyc_valid && $stable(mem_addr)));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .cpu_stb   (cpu_stb),
    .ctl_stb   (ctl_stb),
    .master_en (master_en),
    .sec_en    (sec_en),
    .wr_req    (wr_req),
    .adv       (adv),
    .mem_addr  (mem_addr),
    .cyc_valid (cyc_valid),
    .cyc_write (cyc_write)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
    localparam int AW = 8;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          cpu_stb, ctl_stb, master_en, wr_req, adv, interleave;
    logic [NS-1:0] sec_en;
    logic [AW-1:0] mem_addr;
    logic          cyc_valid, cyc_write;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_seq #(.ADDR_W(AW), .NUM_SEC(NS)) dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cpu_stb(cpu_stb),
        .ctl_stb(ctl_stb), .master_en(master_en), .sec_en(sec_en),
        .wr_req(wr_req), .adv(adv), .interleave(interleave),
        .mem_addr(mem_addr), .cyc_valid(cyc_valid), .cyc_write(cyc_write)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic t, input logic me,
                         input logic [NS-1:0] se, input logic w,
                         input logic a, input logic il, input logic [AW-1:0] ad);
        cpu_stb = c; ctl_stb = t; master_en = me; sec_en = se;
        wr_req = w; adv = a; interleave = il; addr_in = ad;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 1, 2'b11, 0, 0, 0, 8'h00);
        tick(); tick();
        chk("R13 valid", cyc_valid, 0);
        chk("R13 write", cyc_write, 0);
        chk("R13 addr", mem_addr, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R12: every start address in both orders, past the wrap
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                drive(0, 1, 1, 2'b11, 0, 0, m[0], a[7:0]);
                tick();
                chk("R1 addr", mem_addr, a);
                chk("R1 valid", cyc_valid, 1);
                for (int k = 1; k <= 6; k++) begin
                    int lo;
                    drive(0, 0, 1, 2'b11, 0, 1, m[0], 8'hFF);
                    tick();
                    lo = (m == 1) ? ((a & 3) ^ (k % 4)) : (((a & 3) + k) % 4);
                    if (k >= 4)
                        chk("R12 wrap", mem_addr, (a & 8'hFC) | lo);
                    else if (m == 1)
                        chk("R4 interleave", mem_addr, (a & 8'hFC) | lo);
                    else
                        chk("R3 linear", mem_addr, (a & 8'hFC) | lo);
                    chk("R2 upper", mem_addr >> 2, a >> 2);
                end
            end
        end

        // R8: wait states hold the address
        drive(0, 1, 1, 2'b11, 0, 0, 0, 8'h5A); tick();
        drive(0, 0, 1, 2'b11, 0, 1, 0, 8'h00); tick();
        chk("R8 step", mem_addr, 8'h5B);
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 1, 2'b11, 0, 0, 0, 8'h33); tick();
            chk("R8 hold", mem_addr, 8'h5B);
        end

        // R5: processor strobe blocked by master enable
        drive(1, 0, 0, 2'b11, 1, 0, 0, 8'hC4); tick();
        chk("R5 addr", mem_addr, 8'h5B);
        chk("R5 valid", cyc_valid, 1);
        chk("R5 write", cyc_write, 0);

        // R6: controller strobe taken without master enable -> deselect
        drive(0, 1, 0, 2'b11, 0, 0, 0, 8'h77); tick();
        chk("R6 valid", cyc_valid, 0);

        // R14: advance while idle
        drive(0, 0, 1, 2'b11, 0, 1, 0, 8'h00); tick();
        chk("R14 valid", cyc_valid, 0);
        chk("R14 addr", mem_addr, 8'h5B);

        // R7: restart in the middle of a burst
        drive(0, 1, 1, 2'b11, 0, 0, 0, 8'h10); tick();
        drive(0, 0, 1, 2'b11, 0, 1, 0, 8'h00); tick();
        drive(0, 0, 1, 2'b11, 0, 1, 0, 8'h00); tick();
        chk("R7 pre", mem_addr, 8'h12);
        drive(0, 1, 1, 2'b11, 0, 0, 0, 8'h23); tick();
        chk("R7 load", mem_addr, 8'h23);
        drive(0, 0, 1, 2'b11, 0, 1, 0, 8'h00); tick();
        chk("R7 beat1", mem_addr, 8'h20);

        // R9: cycle type
        drive(0, 1, 1, 2'b11, 1, 0, 0, 8'h44); tick();
        chk("R9 ctl write", cyc_write, 1);
        drive(1, 0, 1, 2'b11, 1, 0, 0, 8'h48); tick();
        chk("R9 cpu read", cyc_write, 0);
        chk("R9 cpu valid", cyc_valid, 1);

        // R10: both strobes, processor wins
        drive(0, 1, 1, 2'b11, 1, 0, 0, 8'h50); tick();
        chk("R10 setup", cyc_write, 1);
        drive(1, 1, 1, 2'b11, 1, 0, 0, 8'h61); tick();
        chk("R10 write", cyc_write, 0);
        chk("R10 addr", mem_addr, 8'h61);

        // R11: each secondary enable alone forces a deselect
        for (int s = 0; s < NS; s++) begin
            drive(0, 1, 1, 2'b11, 0, 0, 0, 8'h70); tick();
            chk("R11 setup", cyc_valid, 1);
            drive(1, 0, 1, ~(2'b01 << s), 0, 0, 0, 8'h80); tick();
            chk("R11 valid", cyc_valid, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule